// File: doc/BRIEF.md
# Pipelined Integer Multiply Unit

This unit sits beside a 64-bit execute stage and performs every integer multiply that stage issues. The execute stage passes in two operands that have already been widened to 65 bits, plus an operation code, a destination register number, a record flag, an overflow-check flag, a 32-bit-mode flag and the current carry/overflow status bits. A fixed number of cycles later the unit hands back the selected 64-bit result together with the register number, the record flag and the status bits, updated where required.

The operands arrive already widened. In 32-bit signed mode, bit 31 is copied into bits 64:32. In 32-bit unsigned mode, bits 64:32 are zero. In 64-bit mode, bit 64 repeats bit 63 for signed work and is zero for unsigned work. Because of this, one signed 65x65 product serves all three operations: the low doubleword, the high doubleword, and the high word of a 32x32 multiply.

The unit also drives a stall line. The execute stage holds stall while a multiply is in flight and drops it in the cycle the result comes back. The pipeline depth is a parameter with a default of 4.

Top module: `mul_unit`

## Requirements
- R1: A valid input in cycle t produces `outValid` in cycle t+DEPTH and in no other cycle. That output carries the `inDest` and `inRc` given with the input.
- R2: Operation code 0 (low) returns bits 63:0 of the signed product of the two 65-bit operands.
- R3: Operation code 1 (high) returns bits 127:64 of that product.
- R4: Operation code 2 (high word) returns product bits 63:32 in both result halves: {p[63:32], p[63:32]}.
- R5: `outStatWe` equals `inOe` only when the operation code is 0. For codes 1, 2 and 3 it is 0 and `outStat` equals `statIn`. Code 3 returns the same data as code 0. The status encoding is: bit 2 SO, bit 1 OV, bit 0 OV32.
- R6: When the overflow check is active, OV and OV32 are both set if the product falls outside the signed 64-bit range (64-bit mode) or outside the signed 32-bit range (32-bit mode). Otherwise both are cleared.
- R7: When the overflow check is active, SO out is SO in ORed with the new OV, so SO is never cleared.
- R8: A synchronous reset discards every multiply in flight. `outValid` stays low for the first DEPTH cycles after reset is released, and `stall` is low while nothing has been issued.
- R9: Valid inputs on consecutive cycles each produce their own result, in issue order, one per cycle.
- R10: `stall` is high in the cycle a multiply is issued and in every later cycle until its result cycle. In the result cycle it is low unless another multiply is issued or still in flight.
- R11: While `outValid` is low, `outRc` and `outStatWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Issue a multiply this cycle |
| inOp | input | 2 | 0 low, 1 high, 2 high word, 3 treated as low without status |
| inA | input | 65 | First operand, pre-widened |
| inB | input | 65 | Second operand, pre-widened |
| inDest | input | 5 | Destination register number |
| inRc | input | 1 | Record flag |
| inOe | input | 1 | Overflow-check flag |
| inIs32 | input | 1 | 32-bit mode for overflow detection |
| statIn | input | 3 | Current status bits {SO, OV, OV32} |
| outValid | output | 1 | Result present |
| outData | output | 64 | Selected result |
| outDest | output | 5 | Destination register number |
| outRc | output | 1 | Record flag |
| outStatWe | output | 1 | Status bits should be written |
| outStat | output | 3 | Status bits {SO, OV, OV32} |
| stall | output | 1 | A multiply is in flight and its result has not yet returned |

## Verification
The hardest case to reach is a reset that lands while several multiplies are in flight. Those results must vanish, and later results must not be shifted by the lost slots. The bench therefore issues back-to-back operations and asserts reset two cycles later. Random operands rarely land near the overflow boundaries, so the bench also directs the extreme signed operands, a 32-bit product just past the signed word range, and an incoming SO with no new overflow. Random operands are shrunk in a quarter of the cases so that both overflow outcomes occur.

// File: rtl/mul_pkg.sv
package mul_pkg;
  localparam int XLEN  = 64;
  localparam int HALF  = XLEN / 2;
  localparam int OPW   = XLEN + 1;
  localparam int PRODW = 2 * OPW;
  localparam int REGW  = 5;
  localparam int STATW = 3;
  localparam int ST_SO   = 2;
  localparam int ST_OV   = 1;
  localparam int ST_OV32 = 0;

  typedef enum logic [1:0] {
    OP_LO   = 2'd0,
    OP_HI   = 2'd1,
    OP_HI32 = 2'd2
  } mulOpE;

  typedef struct packed {
    logic capture;
    logic lastValid;
  } mulStrobeS;

  typedef struct packed {
    logic [PRODW-1:0] prod;
    logic [1:0]       op;
    logic [REGW-1:0]  dest;
    logic             rc;
    logic             oe;
    logic             is32;
    logic [STATW-1:0] stat;
  } mulStageS;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl import mul_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output logic      outValid,
  output logic      stall,
  output mulStrobeS strobe
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [DEPTH-1:0] MID_MASK = DEPTH'((1 << (DEPTH - 1)) - 1);

  logic [DEPTH-1:0] validQ;
  logic [CW-1:0]    sinceRst;

  always_ff @(posedge clk) begin
    if (rst) validQ <= '0;
    else     validQ <= DEPTH'({validQ, inValid});
  end

  assign outValid         = validQ[DEPTH-1];
  assign stall            = inValid | (|(validQ & MID_MASK));
  assign strobe.capture   = inValid;
  assign strobe.lastValid = validQ[DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= '0;
    else if (sinceRst < CW'(DEPTH)) sinceRst <= sinceRst + 1'b1;
  end

  // R8: quiet output for the first DEPTH cycles after reset
  p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
    (sinceRst < CW'(DEPTH)) |-> !outValid);

  // R10: stall holds until the result cycle
  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    stall |=> (stall || outValid));

  // R1: a result is always preceded by a stalled cycle
  p_result_after_stall_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(stall));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath import mul_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  mulStrobeS        strobe,
  input  logic [1:0]       inOp,
  input  logic [OPW-1:0]   inA,
  input  logic [OPW-1:0]   inB,
  input  logic [REGW-1:0]  inDest,
  input  logic             inRc,
  input  logic             inOe,
  input  logic             inIs32,
  input  logic [STATW-1:0] statIn,
  output logic [XLEN-1:0]  outData,
  output logic [REGW-1:0]  outDest,
  output logic             outRc,
  output logic             outStatWe,
  output logic [STATW-1:0] outStat
);
  mulStageS stageQ [DEPTH];
  mulStageS entry;
  mulStageS last;
  logic [XLEN-1:0] res;
  logic fit64, fit32, ovf;

  always_comb begin
    entry = '0;
    if (strobe.capture) begin
      entry.prod = {{OPW{inA[OPW-1]}}, inA} * {{OPW{inB[OPW-1]}}, inB};
      entry.op   = inOp;
      entry.dest = inDest;
      entry.rc   = inRc;
      entry.oe   = inOe && (inOp == OP_LO);
      entry.is32 = inIs32;
      entry.stat = statIn;
    end
  end

  always_ff @(posedge clk) begin
    stageQ[0] <= entry;
    for (int i = DEPTH - 1; i > 0; i--) stageQ[i] <= stageQ[i-1];
  end

  always_comb begin
    last  = stageQ[DEPTH-1];
    fit64 = (&last.prod[PRODW-1:XLEN-1]) | ~(|last.prod[PRODW-1:XLEN-1]);
    fit32 = (&last.prod[XLEN-1:HALF-1]) | ~(|last.prod[XLEN-1:HALF-1]);
    ovf   = last.is32 ? !fit32 : !fit64;
    case (last.op)
      OP_HI:   res = last.prod[2*XLEN-1:XLEN];
      OP_HI32: res = {2{last.prod[XLEN-1:HALF]}};
      default: res = last.prod[XLEN-1:0];
    endcase
    outData   = strobe.lastValid ? res : '0;
    outDest   = strobe.lastValid ? last.dest : '0;
    outRc     = strobe.lastValid & last.rc;
    outStatWe = strobe.lastValid & last.oe;
    outStat   = '0;
    if (strobe.lastValid) begin
      outStat = last.stat;
      if (last.oe) begin
        outStat[ST_OV]   = ovf;
        outStat[ST_OV32] = ovf;
        outStat[ST_SO]   = last.stat[ST_SO] | ovf;
      end
    end
  end

  // R5: status write only for the low operation
  p_oe_low_only_r5: assert property (@(posedge clk) disable iff (rst)
    outStatWe |-> (last.op == OP_LO));

  // R7: incoming SO is never lost
  p_so_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.lastValid && last.stat[ST_SO]) |-> outStat[ST_SO]);

  // R7: a new overflow also raises SO
  p_ov_sets_so_r7: assert property (@(posedge clk) disable iff (rst)
    (outStatWe && outStat[ST_OV]) |-> outStat[ST_SO]);

  // R4: high word result has matching halves
  p_hi32_halves_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.lastValid && last.op == OP_HI32) |-> (outData[XLEN-1:HALF] == outData[HALF-1:0]));
endmodule

// File: rtl/mul_unit.sv
module mul_unit import mul_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [1:0]       inOp,
  input  logic [OPW-1:0]   inA,
  input  logic [OPW-1:0]   inB,
  input  logic [REGW-1:0]  inDest,
  input  logic             inRc,
  input  logic             inOe,
  input  logic             inIs32,
  input  logic [STATW-1:0] statIn,
  output logic             outValid,
  output logic [XLEN-1:0]  outData,
  output logic [REGW-1:0]  outDest,
  output logic             outRc,
  output logic             outStatWe,
  output logic [STATW-1:0] outStat,
  output logic             stall
);
  mulStrobeS strobe;

  mul_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .outValid(outValid), .stall(stall), .strobe(strobe)
  );

  mul_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inOp(inOp), .inA(inA), .inB(inB), .inDest(inDest),
    .inRc(inRc), .inOe(inOe), .inIs32(inIs32), .statIn(statIn),
    .outData(outData), .outDest(outDest), .outRc(outRc),
    .outStatWe(outStatWe), .outStat(outStat)
  );
endmodule

// File: tb/mul_unit_test.sv
`timescale 1ns/1ps
module mul_unit_test;
  localparam int D = 4;
  localparam int RING = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [1:0] inOp = '0;
  logic [64:0] inA = '0, inB = '0;
  logic [4:0] inDest = '0;
  logic inRc = 1'b0, inOe = 1'b0, inIs32 = 1'b0;
  logic [2:0] statIn = '0;
  logic outValid;
  logic [63:0] outData;
  logic [4:0] outDest;
  logic outRc, outStatWe;
  logic [2:0] outStat;
  logic stall;

  mul_unit #(.DEPTH(D)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp), .inA(inA), .inB(inB),
    .inDest(inDest), .inRc(inRc), .inOe(inOe), .inIs32(inIs32), .statIn(statIn),
    .outValid(outValid), .outData(outData), .outDest(outDest), .outRc(outRc),
    .outStatWe(outStatWe), .outStat(outStat), .stall(stall)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  int sinceRst = 0;
  bit done = 0;

  logic        expV    [RING];
  logic [63:0] expData [RING];
  logic [4:0]  expDest [RING];
  logic        expRc   [RING];
  logic        expWe   [RING];
  logic [2:0]  expStat [RING];
  logic [1:0]  expOp   [RING];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clearRing();
    for (int i = 0; i < RING; i++) expV[i] = 1'b0;
  endtask

  function automatic logic [64:0] widen(logic [63:0] x, logic is32, logic sgn);
    if (is32) return sgn ? {{33{x[31]}}, x[31:0]} : {33'b0, x[31:0]};
    return sgn ? {x[63], x} : {1'b0, x};
  endfunction

  task automatic issue(input logic v, input logic [1:0] op, input logic [63:0] x, input logic [63:0] y,
                       input logic is32, input logic sgn, input logic [4:0] dest,
                       input logic rc, input logic oe, input logic [2:0] st);
    int s;
    logic expStall;
    logic signed [129:0] p;
    logic signed [129:0] hi64, lo64, hi32, lo32;
    logic [64:0] a, b;
    logic ov, oeEff;
    string tagV;
    @(negedge clk);
    s = cyc % RING;
    tagV = (sinceRst < D) ? "R8" : "R1 R9";
    if (expV[s]) begin
      chk("R1 R9 valid", {63'b0, outValid}, 64'd1);
      chk(expOp[s] == 2'd1 ? "R3 data" : (expOp[s] == 2'd2 ? "R4 data" : "R2 data"), outData, expData[s]);
      chk("R1 dest", {59'b0, outDest}, {59'b0, expDest[s]});
      chk("R1 rc", {63'b0, outRc}, {63'b0, expRc[s]});
      chk("R5 statWe", {63'b0, outStatWe}, {63'b0, expWe[s]});
      chk("R5 R6 R7 stat", {61'b0, outStat}, {61'b0, expStat[s]});
    end else begin
      chk({tagV, " idle valid"}, {63'b0, outValid}, 64'd0);
      chk("R11 idle rc/statWe", {62'b0, outRc, outStatWe}, 64'd0);
    end
    expV[s] = 1'b0;
    a = widen(x, is32, sgn);
    b = widen(y, is32, sgn);
    inValid = v; inOp = op; inA = a; inB = b; inDest = dest;
    inRc = rc; inOe = oe; inIs32 = is32; statIn = st;
    #1;
    expStall = v;
    for (int j = 1; j < D; j++) expStall |= expV[(cyc + j) % RING];
    chk("R10 stall", {63'b0, stall}, {63'b0, expStall});
    if (v) begin
      p = $signed(a) * $signed(b);
      hi64 = (130'sd1 <<< 63) - 130'sd1;  lo64 = -(130'sd1 <<< 63);
      hi32 = (130'sd1 <<< 31) - 130'sd1;  lo32 = -(130'sd1 <<< 31);
      ov = is32 ? (p > hi32 || p < lo32) : (p > hi64 || p < lo64);
      oeEff = oe && (op == 2'd0);
      s = (cyc + D) % RING;
      expV[s] = 1'b1;
      expOp[s] = op;
      case (op)
        2'd1: expData[s] = p[127:64];
        2'd2: expData[s] = {p[63:32], p[63:32]};
        default: expData[s] = p[63:0];
      endcase
      expDest[s] = dest;
      expRc[s] = rc;
      expWe[s] = oeEff;
      expStat[s] = oeEff ? {st[2] | ov, ov, ov} : st;
    end
    cyc++;
    sinceRst++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(1'b0, 2'd0, 64'd0, 64'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b0; inOe = 1'b0; inRc = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clearRing();
    cyc = 0;
    sinceRst = 0;
    #1;
    chk("R8 reset valid", {63'b0, outValid}, 64'd0);
    chk("R8 reset stall", {63'b0, stall}, 64'd0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual hung expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    clearRing();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R8 reset valid", {63'b0, outValid}, 64'd0);
    chk("R8 reset stall", {63'b0, stall}, 64'd0);
    idle(D);
    // Directed corners, issued back to back (R9)
    issue(1, 2'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 0, 1, 5'd1, 1, 1, 3'b000); // R6 overflow 64
    issue(1, 2'd0, 64'h0000_0000_7fff_ffff, 64'd2, 1, 1, 5'd2, 0, 1, 3'b000);                   // R6 overflow 32
    issue(1, 2'd0, 64'd3, 64'd5, 0, 1, 5'd3, 1, 1, 3'b100);                                     // R7 sticky SO
    issue(1, 2'd1, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 0, 0, 5'd4, 0, 1, 3'b011); // R3 R5
    issue(1, 2'd2, 64'hffff_ffff, 64'd2, 1, 1, 5'd5, 1, 0, 3'b001);                             // R4 signed
    issue(1, 2'd2, 64'hffff_ffff, 64'hffff_ffff, 1, 0, 5'd6, 0, 0, 3'b000);                     // R4 unsigned
    issue(1, 2'd3, 64'h1234_5678_9abc_def0, 64'h10, 0, 0, 5'd7, 0, 1, 3'b010);                  // R5 code 3
    issue(1, 2'd0, 64'hffff_ffff_ffff_ffff, 64'h7fff_ffff_ffff_ffff, 0, 1, 5'd8, 0, 1, 3'b000); // R6 fits
    idle(D + 1);
    // Reset with results in flight (R8)
    issue(1, 2'd0, 64'd7, 64'd9, 0, 0, 5'd9, 1, 0, 3'b000);
    issue(1, 2'd1, 64'd7, 64'd9, 0, 0, 5'd10, 1, 0, 3'b000);
    doReset();
    idle(D + 2);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if ($urandom % 4 == 0) x = x >> 40;
      if ($urandom % 4 == 0) y = y >> 40;
      issue(($urandom % 4) != 0, 2'($urandom % 3), x, y, 1'($urandom), 1'($urandom),
            5'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
    end
    idle(D + 2);
    finishRun();
  end
endmodule